// File: doc/BRIEF.md
# One-Bit Stream Recorder on Multiplexed-Address DRAM

The block captures a single-bit input, one bit per step, into a 1M x 1 dynamic RAM. It drives the DRAM's shared row/column address bus, its active-low row strobe, column strobe and write enable, and its data input. It reads the DRAM's data output back. Each step is started by a pulse on `step_en`. The step runs a RAS-only refresh of an internal refresh row, then one data access at the current position of a sequential address counter. That counter is twice the bus width.

After reset the block records. Each step writes the live input bit to DRAM and also echoes it to `play_out`. When the address counter rolls over from all ones to zero, the block enters playback for good. From then on, each step reads the next stored bit in the same order, drives it to `play_out`, and wraps around forever until reset. Every strobe phase lasts `PHASE_CYC` clock cycles, so the DRAM's pulse-width and setup limits can be met at any clock rate.

Top module: `bitstream_dram_recorder`

## Requirements
- R1: During reset and in the first cycle after it, `bus_en` is 0 and `dram_ras_n`, `dram_cas_n` and `dram_we_n` are all 1. Without any step pulse, exactly one refresh cycle then follows on its own.
- R2: The address counter is `{row, col}`, with the row in the upper `HALF_W` bits. The row is on `dram_addr` when `dram_ras_n` falls, and the column is on it when `dram_cas_n` falls. The bus does not change in the cycle of either falling edge.
- R3: A record access lowers RAS first, then WE, then CAS. `dram_d` holds the sampled input bit when CAS falls. WE and CAS are only ever low while RAS is low.
- R4: In playback, `dram_we_n` stays 1 the whole time. `play_out` takes the `dram_q` value that is present while CAS is low.
- R5: In record mode, `play_out` equals the input bit written by the most recent step.
- R6: Each access is preceded by a RAS-only refresh, which is RAS low with CAS high. The refresh rows go 0, 1, 2, … modulo 2^HALF_W, starting with the reset-time refresh.
- R7: The address counter starts at 0 after reset and advances by one after each access.
- R8: `playing` is 0 until 2^(2·HALF_W) accesses have completed. It is 1 after that, and it never returns to 0 before reset.
- R9: The playback steps, in order, reproduce the recorded bit stream, wrapping to address 0 after the last address.
- R10: A `step_en` pulse that arrives while a step is still running has no effect. Exactly one access results per accepted pulse.
- R11: Each strobe phase lasts `PHASE_CYC` cycles, so a refresh holds RAS low for exactly `PHASE_CYC` cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| step_en | input | 1 | Starts one refresh-plus-access step when idle |
| sample_in | input | 1 | Bit to be recorded |
| dram_addr | output | HALF_W | Multiplexed row/column/refresh address |
| dram_ras_n | output | 1 | Row strobe, active low |
| dram_cas_n | output | 1 | Column strobe, active low |
| dram_we_n | output | 1 | Write enable, active low |
| dram_d | output | 1 | Data written to DRAM |
| dram_q | input | 1 | Data read from DRAM |
| bus_en | output | 1 | Address/data outputs valid (0 only right after reset) |
| play_out | output | 1 | Echoed input while recording, stored bit while playing |
| playing | output | 1 | Sticky playback mode flag |

## Verification
The bound checker tests the strobe rules on every cycle: strobes are idle while the bus is disabled, WE and CAS are never low without RAS, the bus is stable on each strobe fall, WE stays off in playback, and the mode flag is sticky. Some behaviours depend on the data path, on ordering across whole steps, or on counting over time, and only the bench's scenarios can show them. These are: the addresses presented to a DRAM stub at each access, the refresh-row sequence and the refresh pulse width, the exact step at which the address wraps into playback, faithful replay of a random recorded stream across more than one wrap, and the rejection of step pulses that arrive mid-sequence.

// File: rtl/bsr_pkg.sv
package bsr_pkg;

   typedef enum logic [3:0] {
      ST_OFF,
      ST_RF_SET,
      ST_RF_LOW,
      ST_RF_END,
      ST_IDLE,
      ST_ROW,
      ST_RAS,
      ST_COL,
      ST_WE,
      ST_CAS,
      ST_DONE
   } seq_state_t;

   typedef enum logic [1:0] {
      BUS_REF,
      BUS_ROW,
      BUS_COL
   } bus_sel_t;

endpackage

// File: rtl/bsr_phase_timer.sv
module bsr_phase_timer #(
   parameter int PHASE_CYC = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic run,
   output logic expired
);
   localparam int CW = (PHASE_CYC > 1) ? $clog2(PHASE_CYC) : 1;

   generate
      if (PHASE_CYC == 1) begin : g_single
         assign expired = run;
      end else begin : g_count
         logic [CW-1:0] cnt;
         assign expired = run && (cnt == CW'(PHASE_CYC - 1));
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               cnt <= '0;
            end else if (!run || expired) begin
               cnt <= '0;
            end else begin
               cnt <= cnt + CW'(1);
            end
         end
      end
   endgenerate

endmodule

// File: rtl/bsr_wrap_counter.sv
module bsr_wrap_counter #(
   parameter int W = 10
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         inc,
   output logic [W-1:0] value,
   output logic         wrap
);
   assign wrap = inc && (&value);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         value <= '0;
      end else if (inc) begin
         value <= value + W'(1);
      end
   end

endmodule

// File: rtl/bsr_strobe_seq.sv
module bsr_strobe_seq
   import bsr_pkg::*;
(
   input  logic     clk,
   input  logic     rst_n,
   input  logic     step_en,
   input  logic     playing,
   input  logic     phase_done,
   output logic     timer_run,
   output logic     ras_n,
   output logic     cas_n,
   output logic     we_n,
   output logic     bus_en,
   output bus_sel_t bus_sel,
   output logic     take_sample,
   output logic     take_q,
   output logic     ref_inc,
   output logic     addr_inc
);
   seq_state_t st, nx;
   logic       init_pend;

   always_comb begin
      nx = st;
      case (st)
         ST_OFF:    nx = ST_RF_SET;
         ST_IDLE:   if (step_en)    nx = ST_RF_SET;
         ST_RF_SET: if (phase_done) nx = ST_RF_LOW;
         ST_RF_LOW: if (phase_done) nx = ST_RF_END;
         ST_RF_END: if (phase_done) nx = init_pend ? ST_IDLE : ST_ROW;
         ST_ROW:    if (phase_done) nx = ST_RAS;
         ST_RAS:    if (phase_done) nx = ST_COL;
         ST_COL:    if (phase_done) nx = playing ? ST_CAS : ST_WE;
         ST_WE:     if (phase_done) nx = ST_CAS;
         ST_CAS:    if (phase_done) nx = ST_DONE;
         ST_DONE:   if (phase_done) nx = ST_IDLE;
         default:   nx = ST_OFF;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st        <= ST_OFF;
         init_pend <= 1'b1;
      end else begin
         st <= nx;
         if (st == ST_RF_END && phase_done) begin
            init_pend <= 1'b0;
         end
      end
   end

   assign timer_run   = (st != ST_OFF) && (st != ST_IDLE);
   assign bus_en      = (st != ST_OFF);
   assign ras_n       = !(st == ST_RF_LOW || st == ST_RAS || st == ST_COL ||
                          st == ST_WE || st == ST_CAS);
   assign cas_n       = (st != ST_CAS);
   assign we_n        = !(!playing && (st == ST_WE || st == ST_CAS));
   assign take_sample = (st == ST_ROW) && phase_done && !playing;
   assign take_q      = (st == ST_CAS) && phase_done && playing;
   assign ref_inc     = (st == ST_RF_END) && phase_done;
   assign addr_inc    = (st == ST_DONE) && phase_done;

   always_comb begin
      case (st)
         ST_ROW, ST_RAS:                 bus_sel = BUS_ROW;
         ST_COL, ST_WE, ST_CAS, ST_DONE: bus_sel = BUS_COL;
         default:                        bus_sel = BUS_REF;
      endcase
   end

endmodule

// File: rtl/bitstream_dram_recorder.sv
module bitstream_dram_recorder
   import bsr_pkg::*;
#(
   parameter int HALF_W    = 10,
   parameter int PHASE_CYC = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              step_en,
   input  logic              sample_in,
   output logic [HALF_W-1:0] dram_addr,
   output logic              dram_ras_n,
   output logic              dram_cas_n,
   output logic              dram_we_n,
   output logic              dram_d,
   input  logic              dram_q,
   output logic              bus_en,
   output logic              play_out,
   output logic              playing
);
   localparam int ADDR_W = 2 * HALF_W;

   generate
      if (HALF_W < 1) begin : g_bad_half
         $error("HALF_W must be at least 1");
      end
      if (PHASE_CYC < 1) begin : g_bad_phase
         $error("PHASE_CYC must be at least 1");
      end
   endgenerate

   logic              phase_done, timer_run;
   logic              take_sample, take_q, ref_inc, addr_inc, addr_wrap;
   logic              unused_ref_wrap;
   bus_sel_t          bus_sel;
   logic [ADDR_W-1:0] pos;
   logic [HALF_W-1:0] ref_row;

   bsr_phase_timer #(.PHASE_CYC(PHASE_CYC)) u_timer (
      .clk     (clk),
      .rst_n   (rst_n),
      .run     (timer_run),
      .expired (phase_done)
   );

   bsr_strobe_seq u_seq (
      .clk         (clk),
      .rst_n       (rst_n),
      .step_en     (step_en),
      .playing     (playing),
      .phase_done  (phase_done),
      .timer_run   (timer_run),
      .ras_n       (dram_ras_n),
      .cas_n       (dram_cas_n),
      .we_n        (dram_we_n),
      .bus_en      (bus_en),
      .bus_sel     (bus_sel),
      .take_sample (take_sample),
      .take_q      (take_q),
      .ref_inc     (ref_inc),
      .addr_inc    (addr_inc)
   );

   bsr_wrap_counter #(.W(ADDR_W)) u_pos (
      .clk   (clk),
      .rst_n (rst_n),
      .inc   (addr_inc),
      .value (pos),
      .wrap  (addr_wrap)
   );

   bsr_wrap_counter #(.W(HALF_W)) u_ref (
      .clk   (clk),
      .rst_n (rst_n),
      .inc   (ref_inc),
      .value (ref_row),
      .wrap  (unused_ref_wrap)
   );

   always_comb begin
      case (bus_sel)
         BUS_ROW: dram_addr = pos[ADDR_W-1:HALF_W];
         BUS_COL: dram_addr = pos[HALF_W-1:0];
         default: dram_addr = ref_row;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         dram_d   <= 1'b0;
         play_out <= 1'b0;
         playing  <= 1'b0;
      end else begin
         if (take_sample) begin
            dram_d   <= sample_in;
            play_out <= sample_in;
         end else if (take_q) begin
            play_out <= dram_q;
         end
         if (addr_wrap) begin
            playing <= 1'b1;
         end
      end
   end

endmodule

// File: rtl/bsr_checker.sv
module bsr_checker #(
   parameter int HALF_W = 10
) (
   input logic              clk,
   input logic              rst_n,
   input logic [HALF_W-1:0] dram_addr,
   input logic              dram_ras_n,
   input logic              dram_cas_n,
   input logic              dram_we_n,
   input logic              bus_en,
   input logic              playing
);
   a_r1_idle_strobes: assert property (@(posedge clk) disable iff (!rst_n)
      !bus_en |-> (dram_ras_n && dram_cas_n && dram_we_n));

   a_r3_cas_under_ras: assert property (@(posedge clk) disable iff (!rst_n)
      !dram_cas_n |-> !dram_ras_n);

   a_r3_we_under_ras: assert property (@(posedge clk) disable iff (!rst_n)
      !dram_we_n |-> !dram_ras_n);

   a_r2_row_stable: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(dram_ras_n) |-> $stable(dram_addr));

   a_r2_col_stable: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(dram_cas_n) |-> $stable(dram_addr));

   a_r4_no_write_playing: assert property (@(posedge clk) disable iff (!rst_n)
      playing |-> dram_we_n);

   a_r8_mode_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      playing |=> playing);

endmodule

bind bitstream_dram_recorder bsr_checker #(.HALF_W(HALF_W)) u_bsr_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .dram_addr  (dram_addr),
   .dram_ras_n (dram_ras_n),
   .dram_cas_n (dram_cas_n),
   .dram_we_n  (dram_we_n),
   .bus_en     (bus_en),
   .playing    (playing)
);

// File: tb/bitstream_dram_recorder_bench.sv
module bitstream_dram_recorder_bench;
   localparam int CLK_PERIOD = 10;
   localparam int H          = 3;
   localparam int P          = 2;
   localparam int N          = 1 << (2 * H);
   localparam int STEP_WAIT  = 12 * P;

   logic         clk = 1'b0;
   logic         rst_n;
   logic         step_en;
   logic         sample_in;
   logic [H-1:0] dram_addr;
   logic         dram_ras_n, dram_cas_n, dram_we_n, dram_d, dram_q;
   logic         bus_en, play_out, playing;

   int total = 0;
   int bad   = 0;
   bit finished = 0;

   always #(CLK_PERIOD / 2) clk = ~clk;

   bitstream_dram_recorder #(.HALF_W(H), .PHASE_CYC(P)) u_bitstream_dram_recorder (
      .clk        (clk),
      .rst_n      (rst_n),
      .step_en    (step_en),
      .sample_in  (sample_in),
      .dram_addr  (dram_addr),
      .dram_ras_n (dram_ras_n),
      .dram_cas_n (dram_cas_n),
      .dram_we_n  (dram_we_n),
      .dram_d     (dram_d),
      .dram_q     (dram_q),
      .bus_en     (bus_en),
      .play_out   (play_out),
      .playing    (playing)
   );

   task automatic check(input bit ok, input string req, input int act, input int exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   function automatic int exp_pos(input int k);
      return k % N;
   endfunction

   // behavioural DRAM stub and port monitors
   logic         mem [N];
   bit           rec [N];
   logic [H-1:0] lat_row, lat_col;
   int           acc_count = 0;
   int           ref_count = 0;
   int           ref_exp   = 0;
   int           ras_low_cyc = 0;
   bit           cas_seen  = 0;
   bit           ref_pend  = 0;

   initial begin
      for (int i = 0; i < N; i++) mem[i] = 1'b0;
      lat_row = '0;
      lat_col = '0;
   end

   assign dram_q = mem[{lat_row, lat_col}];

   always @(negedge clk) if (rst_n && !dram_ras_n) ras_low_cyc++;

   always @(negedge dram_ras_n) begin
      lat_row     = dram_addr;
      cas_seen    = 0;
      ras_low_cyc = 0;
   end

   always @(posedge dram_ras_n) if (rst_n && !cas_seen) begin
      // R6: RAS-only refresh with incrementing row; R11: pulse width
      check(int'(lat_row) == ref_exp % (1 << H), "R6 refresh row", lat_row, ref_exp % (1 << H));
      check(ras_low_cyc == P, "R11 refresh RAS width", ras_low_cyc, P);
      ref_exp++;
      ref_count++;
      ref_pend = 1;
   end

   always @(negedge dram_cas_n) begin
      lat_col  = dram_addr;
      cas_seen = 1;
      check(ref_pend, "R6 refresh before access", ref_pend, 1);
      ref_pend = 0;
      // R2, R7: {row, col} equals the sequential position
      check(int'({lat_row, dram_addr}) == exp_pos(acc_count), "R2/R7 access address",
            {lat_row, dram_addr}, exp_pos(acc_count));
      if (acc_count < N) begin
         // R3: write access, WE already low, data set up
         check(!dram_we_n, "R3 WE low before CAS", dram_we_n, 0);
         check(dram_d == rec[acc_count], "R3 data at CAS", dram_d, rec[acc_count]);
         if (!dram_we_n) mem[{lat_row, dram_addr}] = dram_d;
      end else begin
         check(dram_we_n, "R4 WE high in playback", dram_we_n, 1);
      end
      acc_count++;
   end

   task automatic do_step(input bit extra_pulse);
      @(negedge clk);
      step_en = 1'b1;
      @(negedge clk);
      step_en = 1'b0;
      if (extra_pulse) begin
         repeat (3) @(negedge clk);
         step_en = 1'b1;
         @(negedge clk);
         step_en = 1'b0;
      end
      repeat (STEP_WAIT) @(negedge clk);
   endtask

   initial begin
      void'($urandom(32'd1234));
      rst_n     = 1'b0;
      step_en   = 1'b0;
      sample_in = 1'b0;
      repeat (3) @(negedge clk);
      // R1: reset state
      check(bus_en == 0, "R1 bus disabled in reset", bus_en, 0);
      check(dram_ras_n && dram_cas_n && dram_we_n, "R1 strobes idle in reset",
            {dram_ras_n, dram_cas_n, dram_we_n}, 7);
      rst_n = 1'b1;
      @(posedge clk);
      @(negedge clk);
      repeat (STEP_WAIT) @(negedge clk);
      check(ref_count == 1, "R1 single init refresh", ref_count, 1);
      check(acc_count == 0, "R1 no access without step", acc_count, 0);
      check(bus_en == 1, "R1 bus enabled after reset", bus_en, 1);

      // record phase
      for (int i = 0; i < N; i++) begin
         bit b;
         if (i < 4) b = (i != 1);
         else if (i >= N - 3) b = 1'b1;
         else b = bit'($urandom % 2);
         rec[i]    = b;
         sample_in = b;
         do_step(i == 5 || i == 6 || i == N - 1);
         check(acc_count == i + 1, "R10 one access per accepted step", acc_count, i + 1);
         check(play_out == b, "R5 echo of input", play_out, b);
         check(mem[i] == b, "R3 bit stored", mem[i], b);
         check(playing == (i == N - 1), "R8 mode switch at wrap", playing, i == N - 1);
      end

      // playback phase, more than one wrap
      for (int j = 0; j < 2 * N; j++) begin
         bit e;
         e = rec[j % N];
         sample_in = ~e;
         do_step(j == 2 || j == N);
         check(play_out == e, "R9 replay matches record", play_out, e);
         check(playing == 1, "R8 mode stays playback", playing, 1);
      end
      check(acc_count == 3 * N, "R10 total accesses", acc_count, 3 * N);
      check(ref_count == 3 * N + 1, "R6 total refreshes", ref_count, 3 * N + 1);

      if (!finished) begin
         finished = 1;
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!finished) begin
         finished = 1;
         total++;
         bad++;
         $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

endmodule